// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Non-Overlap Timing

This block produces the four gate enables of a full bridge built from external N-channel switches. It has two high-side enables and two low-side enables. A direction input and a PWM input set the pattern. In either direction one high-side switch is held on, and the two low-side switches are driven in complementary fashion from PWM. When a switch is newly commanded on, its turn-on is held back by a programmable number of clock cycles. A switch being turned off is dropped on the next edge. Together these keep the bridge free of overlap.

A master enable gates the whole bridge. It is formed from a watchdog-synchronised flag, the battery window flags, the charge-pump status and the shutdown-level temperature flag. Per-switch desaturation flags are qualified over a programmable number of cycles, and so is a low power-rail flag. A qualified fault blanks every gate on the edge that latches it. The fault stays latched until the PWM input next changes level. Three registered diagnostic outputs report short circuit, supply trouble and the temperature warning. The non-overlap count and the qualification count are both captured while reset is held. All inputs are synchronous to `clk`. Reset is synchronous and active low.

Top module: `hbridge_gate_seq`

## Requirements
- R1: `bridge_on` is 1 one edge after `wd_sync`=1, `bat_uv`=0, `bat_ov`=0, `cp_ok`=1 and `ot_shut`=0 are all sampled together, and it is 0 one edge after any one of these fails.
- R2: While `bridge_on` is 0, all four gate outputs are 0. This includes the reset state, in which every output is 0.
- R3: In steady state with `dir`=0, `gate_h1`=1 and `gate_h2`=0, `gate_l2` equals `pwm`, and `gate_l1` equals the inverse of `pwm`.
- R4: In steady state with `dir`=1, `gate_h2`=1 and `gate_h1`=0, `gate_l1` equals `pwm`, and `gate_l2` equals the inverse of `pwm`.
- R5: A gate commanded off falls on the first edge that samples the change. Let D be the non-overlap count. A gate commanded on rises D+1 edges after the edge that samples the change of `pwm` or `dir`. A gate that stays commanded on is not interrupted. `gate_l1`/`gate_l2` are never 1 together, and neither are `gate_h1`/`gate_h2`.
- R6: A `dir` change while running drops all four gates on the first edge. The new high side and low side then rise together D+1 edges after that edge.
- R7: With `pwm` held at 1, the low side selected by `dir` stays on without interruption, in both directions.
- R8: Let Q be the qualification count. `desat[i]` uses bit order H1=0, H2=1, L1=2, L2=3. If it is sampled 1 on Q+1 consecutive edges while gate i is on, `diag_sc` goes to 1 and all gates go to 0 on that edge.
- R9: A desaturation flag sampled for Q or fewer consecutive edges raises no fault. A flag on a gate that is off raises no fault, however long it lasts.
- R10: `pbat_low` sampled 1 on Q+1 consecutive edges latches the same fault and blanks the gates. Q consecutive edges raise no fault.
- R11: A latched fault holds until an edge that samples `pwm` at a level different from the previous edge. On that edge it clears, and the gates resume per `dir` after the R5 delay.
- R12: `diag_sup` is registered `!cp_ok | bat_ov | bat_uv`. `diag_temp` is registered `ot_warn`. `ot_warn` alone does not drop `bridge_on`.
- R13: `dead_cfg` and `qual_cfg` are captured only while `rst_n` is 0. Changing them afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| dead_cfg | input | 16 | Non-overlap count D in cycles |
| qual_cfg | input | 16 | Fault qualification count Q in cycles |
| wd_sync | input | 1 | A valid watchdog trigger has been accepted |
| bat_uv | input | 1 | Battery undervoltage |
| bat_ov | input | 1 | Battery overvoltage |
| cp_ok | input | 1 | Charge pump at its minimum voltage |
| ot_warn | input | 1 | First-level overtemperature warning |
| ot_shut | input | 1 | Second-level overtemperature |
| dir | input | 1 | Direction, 0 forward, 1 reverse |
| pwm | input | 1 | Speed modulation input |
| desat | input | 4 | Per-switch desaturation flags, bit 0 H1, 1 H2, 2 L1, 3 L2 |
| pbat_low | input | 1 | Bridge supply rail below its limit |
| gate_h1 | output | 1 | High-side 1 enable |
| gate_h2 | output | 1 | High-side 2 enable |
| gate_l1 | output | 1 | Low-side 1 enable |
| gate_l2 | output | 1 | Low-side 2 enable |
| bridge_on | output | 1 | Registered master enable |
| diag_sc | output | 1 | Latched short-circuit or rail fault |
| diag_sup | output | 1 | Charge pump, overvoltage or undervoltage problem |
| diag_temp | output | 1 | Temperature warning |

## Verification
The bench times the rise of the incoming low side against the exact edge count D+1. A design that counted one cycle short would let the incoming switch rise too early. A design that reloaded from the live configuration port instead of the captured count would show no delay at all.

For faults, the bench holds a flag for exactly Q edges and then for Q+1. An off-by-one counter would either trip on a legal pulse or miss a real short. A flag on a switch that is off must be ignored, or normal braking would shut the bridge down. The fault must survive many cycles with PWM frozen, and must clear only on a PWM level change. A direction reversal must also open every switch before the mirrored pattern starts. A design that kept a low side on across the swap would short one leg.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    localparam int NUM_SW   = 4;
    localparam int NUM_QUAL = NUM_SW + 1;

    typedef enum int unsigned {
        SW_H1 = 0,
        SW_H2 = 1,
        SW_L1 = 2,
        SW_L2 = 3
    } sw_idx_e;

    // Gate pattern for a running bridge; bit positions follow sw_idx_e.
    function automatic logic [NUM_SW-1:0] bridge_pattern(input logic rev, input logic mod);
        logic [NUM_SW-1:0] p;
        p = '0;
        if (!rev) begin
            p[SW_H1] = 1'b1;
            p[SW_L2] = mod;
            p[SW_L1] = ~mod;
        end else begin
            p[SW_H2] = 1'b1;
            p[SW_L1] = mod;
            p[SW_L2] = ~mod;
        end
        return p;
    endfunction

endpackage

// File: rtl/hbs_qual.sv
module hbs_qual #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cond,
    input  logic [W-1:0] limit,
    output logic         trip
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        trip  = cond && (cnt_q >= limit);
        cnt_d = cnt_q;
        if (!cond) begin
            cnt_d = '0;
        end else if (cnt_q < limit) begin
            cnt_d = cnt_q + W'(1);
        end
        if (!rst_n) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hbs_dead_timer.sv
module hbs_dead_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = (cnt_q == '0) && !restart;
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
        if (!rst_n) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
    import hbs_pkg::*;
#(
    parameter int DEAD_W = 16,
    parameter int QUAL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEAD_W-1:0] dead_cfg,
    input  logic [QUAL_W-1:0] qual_cfg,
    input  logic              wd_sync,
    input  logic              bat_uv,
    input  logic              bat_ov,
    input  logic              cp_ok,
    input  logic              ot_warn,
    input  logic              ot_shut,
    input  logic              dir,
    input  logic              pwm,
    input  logic [3:0]        desat,
    input  logic              pbat_low,
    output logic              gate_h1,
    output logic              gate_h2,
    output logic              gate_l1,
    output logic              gate_l2,
    output logic              bridge_on,
    output logic              diag_sc,
    output logic              diag_sup,
    output logic              diag_temp
);
    typedef struct packed {
        logic [NUM_SW-1:0] gate;
        logic [NUM_SW-1:0] cmd;
        logic              sc;
        logic              pwm;
        logic              on;
        logic              dsup;
        logic              dtemp;
        logic [DEAD_W-1:0] dead;
        logic [QUAL_W-1:0] qual;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [NUM_QUAL-1:0] qual_cond;
    logic [NUM_QUAL-1:0] trip;
    logic                on_now;
    logic                sc_next;
    logic [NUM_SW-1:0]   cmd;
    logic                restart;
    logic                dead_done;

    // Fault qualifiers: one per switch (counted only while driven) plus the rail.
    assign qual_cond = {pbat_low, st_q.gate & desat};

    for (genvar i = 0; i < NUM_QUAL; i++) begin : g_qual
        hbs_qual #(.W(QUAL_W)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (qual_cond[i]),
            .limit (st_q.qual),
            .trip  (trip[i])
        );
    end

    // Command process: master enable, fault latch and requested pattern.
    always_comb begin
        on_now  = wd_sync && !bat_uv && !bat_ov && cp_ok && !ot_shut;
        sc_next = (|trip) || (st_q.sc && (pwm == st_q.pwm));
        cmd     = (on_now && !sc_next) ? bridge_pattern(dir, pwm) : '0;
        restart = (cmd != st_q.cmd);
    end

    hbs_dead_timer #(.W(DEAD_W)) u_dead (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .load_val (st_q.dead),
        .done     (dead_done)
    );

    // Next-state process: turn-off immediate, turn-on only once the timer is idle.
    always_comb begin
        st_d       = st_q;
        st_d.cmd   = cmd;
        st_d.gate  = cmd & (st_q.gate | {NUM_SW{dead_done}});
        st_d.sc    = sc_next;
        st_d.pwm   = pwm;
        st_d.on    = on_now;
        st_d.dsup  = !cp_ok || bat_ov || bat_uv;
        st_d.dtemp = ot_warn;
        if (!rst_n) begin
            st_d      = '0;
            st_d.dead = dead_cfg;
            st_d.qual = qual_cfg;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gate_h1   = st_q.gate[SW_H1];
    assign gate_h2   = st_q.gate[SW_H2];
    assign gate_l1   = st_q.gate[SW_L1];
    assign gate_l2   = st_q.gate[SW_L2];
    assign bridge_on = st_q.on;
    assign diag_sc   = st_q.sc;
    assign diag_sup  = st_q.dsup;
    assign diag_temp = st_q.dtemp;
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker (
    input logic clk,
    input logic rst_n,
    input logic dir,
    input logic pwm,
    input logic cp_ok,
    input logic bat_ov,
    input logic bat_uv,
    input logic gate_h1,
    input logic gate_h2,
    input logic gate_l1,
    input logic gate_l2,
    input logic bridge_on,
    input logic diag_sc,
    input logic diag_sup
);
    AST_OFF_WHEN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_on |-> !(gate_h1 || gate_h2 || gate_l1 || gate_l2)); // R2

    AST_NO_LEG_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_l1 && gate_l2) && !(gate_h1 && gate_h2)); // R5

    AST_RISE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_h1) || $rose(gate_h2) || $rose(gate_l1) || $rose(gate_l2))
        |-> ($past(pwm) == $past(pwm, 2)) && ($past(dir) == $past(dir, 2))); // R5

    AST_FAULT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        diag_sc |-> !(gate_h1 || gate_h2 || gate_l1 || gate_l2)); // R8

    AST_DIAG_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (diag_sup == $past(!cp_ok || bat_ov || bat_uv))); // R12
endmodule

bind hbridge_gate_seq hbs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir       (dir),
    .pwm       (pwm),
    .cp_ok     (cp_ok),
    .bat_ov    (bat_ov),
    .bat_uv    (bat_uv),
    .gate_h1   (gate_h1),
    .gate_h2   (gate_h2),
    .gate_l1   (gate_l1),
    .gate_l2   (gate_l2),
    .bridge_on (bridge_on),
    .diag_sc   (diag_sc),
    .diag_sup  (diag_sup)
);

// File: tb/hbridge_gate_seq_bench.sv
module hbridge_gate_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] dead_cfg, qual_cfg;
    logic        wd_sync, bat_uv, bat_ov, cp_ok, ot_warn, ot_shut;
    logic        dir, pwm, pbat_low;
    logic [3:0]  desat;
    logic        gate_h1, gate_h2, gate_l1, gate_l2;
    logic        bridge_on, diag_sc, diag_sup, diag_temp;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hbridge_gate_seq u_hbridge_gate_seq (
        .clk(clk), .rst_n(rst_n), .dead_cfg(dead_cfg), .qual_cfg(qual_cfg),
        .wd_sync(wd_sync), .bat_uv(bat_uv), .bat_ov(bat_ov), .cp_ok(cp_ok),
        .ot_warn(ot_warn), .ot_shut(ot_shut), .dir(dir), .pwm(pwm),
        .desat(desat), .pbat_low(pbat_low),
        .gate_h1(gate_h1), .gate_h2(gate_h2), .gate_l1(gate_l1), .gate_l2(gate_l2),
        .bridge_on(bridge_on), .diag_sc(diag_sc), .diag_sup(diag_sup), .diag_temp(diag_temp)
    );

    // Gate view: bit3 H1, bit2 H2, bit1 L1, bit0 L2.
    function automatic logic [3:0] gates();
        return {gate_h1, gate_h2, gate_l1, gate_l2};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_good();
        wd_sync = 1'b1; bat_uv = 1'b0; bat_ov = 1'b0; cp_ok = 1'b1;
        ot_shut = 1'b0; ot_warn = 1'b0; desat = 4'h0; pbat_low = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; dead_cfg = 16'd3; qual_cfg = 16'd5;
        wd_sync = 1'b0; bat_uv = 1'b0; bat_ov = 1'b0; cp_ok = 1'b0;
        ot_warn = 1'b0; ot_shut = 1'b0; dir = 1'b0; pwm = 1'b0;
        desat = 4'h0; pbat_low = 1'b0;
        tick(4);
        chk("R2 reset gates", 32'(gates()), 32'h0);
        chk("R2 reset flags", 32'({bridge_on, diag_sc, diag_sup, diag_temp}), 32'h0);
        rst_n = 1'b1;
        dead_cfg = 16'd0;   // R13: must be ignored after reset
        qual_cfg = 16'd0;
        tick(1);
    endtask

    task automatic t_on_gating();
        for (int k = 0; k < 5; k++) begin
            set_good(); dir = 1'b0; pwm = 1'b1;
            case (k)
                0: wd_sync = 1'b0;
                1: bat_uv  = 1'b1;
                2: bat_ov  = 1'b1;
                3: cp_ok   = 1'b0;
                default: ot_shut = 1'b1;
            endcase
            tick(8);
            chk("R1 on low", 32'(bridge_on), 32'h0);
            chk("R2 gates off", 32'(gates()), 32'h0);
        end
        set_good();
        tick(8);
        chk("R1 on high", 32'(bridge_on), 32'h1);
    endtask

    task automatic t_forward();
        dir = 1'b0; pwm = 1'b1; tick(8);
        chk("R3 fwd pwm1", 32'(gates()), 32'h9);
        pwm = 1'b0; tick(8);
        chk("R3 fwd pwm0", 32'(gates()), 32'hA);
    endtask

    task automatic t_reverse();
        dir = 1'b1; pwm = 1'b1; tick(8);
        chk("R4 rev pwm1", 32'(gates()), 32'h6);
        pwm = 1'b0; tick(8);
        chk("R4 rev pwm0", 32'(gates()), 32'h5);
    endtask

    task automatic t_deadtime();
        dir = 1'b0; pwm = 1'b1; tick(10);
        pwm = 1'b0; tick(1);
        chk("R5 turn-off one edge", 32'(gates()), 32'h8);
        tick(3);
        chk("R5 R13 still waiting at D", 32'(gates()), 32'h8);
        tick(1);
        chk("R5 turn-on at D+1", 32'(gates()), 32'hA);
        pwm = 1'b1; tick(1);
        chk("R5 rising pwm off", 32'(gates()), 32'h8);
        tick(3);
        chk("R5 rising pwm wait", 32'(gates()), 32'h8);
        tick(1);
        chk("R5 rising pwm on", 32'(gates()), 32'h9);
    endtask

    task automatic t_dir_change();
        dir = 1'b0; pwm = 1'b1; tick(10);
        dir = 1'b1; tick(1);
        chk("R6 all off", 32'(gates()), 32'h0);
        tick(3);
        chk("R6 still off", 32'(gates()), 32'h0);
        tick(1);
        chk("R6 mirrored on", 32'(gates()), 32'h6);
        dir = 1'b0; tick(10);
    endtask

    task automatic t_full_duty();
        int bad;
        dir = 1'b0; pwm = 1'b1; tick(10);
        bad = 0;
        for (int i = 0; i < 150; i++) begin
            tick(1);
            if (gates() !== 4'h9) bad++;
        end
        chk("R7 fwd 100% duty", 32'(bad), 32'h0);
        dir = 1'b1; tick(10);
        bad = 0;
        for (int i = 0; i < 150; i++) begin
            tick(1);
            if (gates() !== 4'h6) bad++;
        end
        chk("R7 rev 100% duty", 32'(bad), 32'h0);
        dir = 1'b0; tick(10);
    endtask

    task automatic t_short();
        dir = 1'b0; pwm = 1'b1; tick(10);
        desat = 4'b1000; tick(5);
        desat = 4'b0000; tick(1);
        chk("R9 Q edges no fault", 32'(diag_sc), 32'h0);
        chk("R9 gates kept", 32'(gates()), 32'h9);
        desat = 4'b0100; tick(20);
        desat = 4'b0000; tick(1);
        chk("R9 off switch ignored", 32'(diag_sc), 32'h0);
        desat = 4'b1000; tick(6);
        chk("R8 fault latched", 32'(diag_sc), 32'h1);
        chk("R8 gates blanked", 32'(gates()), 32'h0);
        desat = 4'b0000;
    endtask

    task automatic t_clear();
        tick(10);
        chk("R11 holds without pwm edge", 32'(diag_sc), 32'h1);
        chk("R11 gates stay off", 32'(gates()), 32'h0);
        pwm = 1'b0; tick(1);
        chk("R11 cleared on pwm edge", 32'(diag_sc), 32'h0);
        tick(3);
        chk("R11 resume waits", 32'(gates()), 32'h0);
        tick(1);
        chk("R11 resumed per dir", 32'(gates()), 32'hA);
    endtask

    task automatic t_pbat();
        pbat_low = 1'b1; tick(5);
        pbat_low = 1'b0; tick(1);
        chk("R10 Q edges no fault", 32'(diag_sc), 32'h0);
        pbat_low = 1'b1; tick(6);
        chk("R10 fault latched", 32'(diag_sc), 32'h1);
        chk("R10 gates blanked", 32'(gates()), 32'h0);
        pbat_low = 1'b0; pwm = 1'b1; tick(6);
        chk("R10 R11 cleared", 32'(diag_sc), 32'h0);
        chk("R10 R11 resumed", 32'(gates()), 32'h9);
    endtask

    task automatic t_diag();
        set_good(); tick(2);
        cp_ok = 1'b0; tick(1);
        chk("R12 cp fail", 32'(diag_sup), 32'h1);
        cp_ok = 1'b1; tick(1);
        chk("R12 cp ok", 32'(diag_sup), 32'h0);
        bat_ov = 1'b1; tick(1);
        chk("R12 ov", 32'(diag_sup), 32'h1);
        bat_ov = 1'b0; bat_uv = 1'b1; tick(1);
        chk("R12 uv", 32'(diag_sup), 32'h1);
        bat_uv = 1'b0; tick(8);
        ot_warn = 1'b1; tick(1);
        chk("R12 warn", 32'(diag_temp), 32'h1);
        chk("R12 warn keeps on", 32'(bridge_on), 32'h1);
        ot_warn = 1'b0; ot_shut = 1'b1; tick(1);
        chk("R12 shut not warn", 32'(diag_temp), 32'h0);
        chk("R1 shut drops on", 32'(bridge_on), 32'h0);
        ot_shut = 1'b0; tick(2);
    endtask

    initial begin
        t_reset();
        set_good();
        t_on_gating();
        t_forward();
        t_reverse();
        t_deadtime();
        t_dir_change();
        t_full_duty();
        t_short();
        t_clear();
        t_pbat();
        t_diag();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule